// File: doc/BRIEF.md
# Filtered Quadrature Decoder with Index Event

This block sits in front of a position counter. It takes two quadrature phase signals and an index signal and passes each one through a two-flop synchronizer. A glitch filter follows, and its length is programmable. The filtered phase pair is decoded into single-cycle increment and decrement strobes. The filtered index produces a single-cycle index strobe when the phase pair sits at a chosen two-bit state.

An 8-bit control register sets how the block behaves:

| Bits | Function |
|------|----------|
| [2:0] | Filter length. A level change is accepted only after `len+1` consecutive equal samples. |
| [3] | Decode enable. |
| [4] | Index enable. |
| [6:5] | Index phase state, compared against `{ph0, ph90}`. |
| [7] | Reserved. It reads as zero. |

A sticky error output flags illegal phase jumps. Only reset clears it.

Top module: `quad_event_frontend`

## Requirements
- R1: After reset, the register reads 0x00, all strobes are low and the error flag is low.
- R2: Register bit 7 always reads 0, whatever value is written. Bits 6:0 read back exactly as written.
- R3: With decode enabled, a filtered step of `{ph0,ph90}` in the order 00→01→11→10→00 produces one `inc_o` pulse of one cycle per step. The reverse order produces one `dec_o` pulse per step.
- R4: With decode enable (bit 3) clear, phase changes produce no `inc_o` and no `dec_o` pulses.
- R5: An input level is accepted only after it has been sampled for `len+1` consecutive clocks, where `len` is bits 2:0. A shorter pulse is ignored.
- R6: With `len`=0, an input change captured at clock edge k shows as a strobe after edge k+3. Each extra filter count adds one cycle.
- R7: With decode enabled, a step where both phases change at once produces no count and sets `err_o`. `err_o` then stays high until reset.
- R8: With index enable (bit 4) set, `idx_o` pulses for one cycle when the filtered index is high and the filtered `{ph0,ph90}` equals bits 6:5. With bit 4 clear, no `idx_o` pulse occurs.
- R9: `inc_o` and `dec_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| ph0_in | input | 1 | Phase-0 input, asynchronous |
| ph90_in | input | 1 | Phase-90 input, asynchronous |
| idx_in | input | 1 | Index input, asynchronous |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| inc_o | output | 1 | Count-up strobe |
| dec_o | output | 1 | Count-down strobe |
| idx_o | output | 1 | Index strobe |
| err_o | output | 1 | Sticky illegal-transition flag |

## Verification
Two cases are hard to reach from the ports.

The first is the filter boundary, where a pulse exactly one sample shorter than the filter length must vanish. The stimulus drives the phase input from the falling edge and holds it for a counted number of clocks. That places exactly `len` and then `len+1` samples into the filter, so both sides of the threshold are hit.

The second is the illegal double-phase step. The filters must be set so that both phases are accepted on the same clock. The bench uses equal filter lengths and changes both inputs in the same cycle for this case.

// File: rtl/quad_event_frontend.sv
module quad_event_frontend #(
  parameter int FLT_W = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ph0_in,
  input  logic       ph90_in,
  input  logic       idx_in,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       inc_o,
  output logic       dec_o,
  output logic       idx_o,
  output logic       err_o
);
  localparam int NIN = 3;

  logic [6:0]       ctrl;
  logic [NIN-1:0]   sync1, sync2, filt;
  logic [FLT_W-1:0] cnt [NIN];
  logic [1:0]       prev_pair;
  logic             hit_q;

  wire [FLT_W-1:0] flen   = ctrl[FLT_W-1:0];
  wire             dec_en = ctrl[3];
  wire             idx_en = ctrl[4];
  wire [1:0]       idx_st = ctrl[6:5];

  wire [1:0] pair     = {filt[0], filt[1]};
  wire [1:0] pos_cur  = {pair[1], pair[1] ^ pair[0]};
  wire [1:0] pos_prev = {prev_pair[1], prev_pair[1] ^ prev_pair[0]};
  wire [1:0] step     = pos_cur - pos_prev;
  wire       hit      = idx_en & filt[2] & (pair == idx_st);

  assign reg_rdata = {1'b0, ctrl};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (reg_we) begin
      ctrl <= reg_wdata[6:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
      filt  <= '0;
      for (int i = 0; i < NIN; i++) cnt[i] <= '0;
    end else begin
      sync1 <= {idx_in, ph90_in, ph0_in};
      sync2 <= sync1;
      for (int i = 0; i < NIN; i++) begin
        if (sync2[i] == filt[i]) begin
          cnt[i] <= '0;
        end else if (cnt[i] == flen) begin
          filt[i] <= sync2[i];
          cnt[i]  <= '0;
        end else begin
          cnt[i] <= cnt[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_pair <= '0;
      inc_o     <= 1'b0;
      dec_o     <= 1'b0;
      err_o     <= 1'b0;
      hit_q     <= 1'b0;
      idx_o     <= 1'b0;
    end else begin
      prev_pair <= pair;
      inc_o     <= dec_en & (step == 2'd1);
      dec_o     <= dec_en & (step == 2'd3);
      if (dec_en && step == 2'd2) err_o <= 1'b1;
      hit_q     <= hit;
      idx_o     <= hit & ~hit_q;
    end
  end
endmodule

// File: rtl/quad_event_frontend_chk.sv
module quad_event_frontend_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] reg_rdata,
  input logic       inc_o,
  input logic       dec_o,
  input logic       idx_o,
  input logic       err_o
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[7] == 1'b0);

  p_count_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    (inc_o || dec_o) |-> $past(reg_rdata[3]));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  p_idx_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
    idx_o |-> $past(reg_rdata[4]));

  p_idx_single_r8: assert property (@(posedge clk) disable iff (rst)
    idx_o |=> !idx_o);

  p_no_both_r9: assert property (@(posedge clk) disable iff (rst)
    !(inc_o && dec_o));
endmodule

bind quad_event_frontend quad_event_frontend_chk u_chk (
  .clk(clk), .rst(rst), .reg_rdata(reg_rdata),
  .inc_o(inc_o), .dec_o(dec_o), .idx_o(idx_o), .err_o(err_o)
);

// File: tb/test_quad_event_frontend.sv
module test_quad_event_frontend;
  logic clk = 0, rst = 1;
  logic ph0 = 0, ph90 = 0, idx = 0, we = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic inc, dec, ix, err;
  int n_chk = 0, n_bad = 0;
  int c_inc = 0, c_dec = 0, c_idx = 0;

  always #2.5 clk = ~clk;

  quad_event_frontend i_quad_event_frontend (
    .clk(clk), .rst(rst), .ph0_in(ph0), .ph90_in(ph90), .idx_in(idx),
    .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata),
    .inc_o(inc), .dec_o(dec), .idx_o(ix), .err_o(err));

  always @(negedge clk) begin
    if (inc) c_inc++;
    if (dec) c_dec++;
    if (ix)  c_idx++;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; ph0 = 0; ph90 = 0; idx = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    c_inc = 0; c_dec = 0; c_idx = 0;
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); we = 1; wdata = v;
    @(negedge clk); we = 0;
  endtask

  task automatic go(logic a, logic b);
    @(negedge clk); ph0 = a; ph90 = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic t_reset_r1();
    do_reset();
    check("R1 rdata", rdata, 0);
    check("R1 strobes", {inc, dec, ix}, 0);
    check("R1 err", err, 0);
  endtask

  task automatic t_reg_r2();
    do_reset();
    wr(8'hFF);
    check("R2 rsvd", rdata, 8'h7F);
    wr(8'h35);
    check("R2 readback", rdata, 8'h35);
  endtask

  task automatic t_fwd_rev_r3();
    do_reset();
    wr(8'h08);
    go(0, 1); go(1, 1); go(1, 0); go(0, 0);
    check("R3 fwd inc", c_inc, 4);
    check("R3 fwd dec", c_dec, 0);
    go(1, 0); go(1, 1); go(0, 1);
    check("R3 rev dec", c_dec, 3);
    check("R3 rev inc", c_inc, 4);
    check("R3 err", err, 0);
  endtask

  task automatic t_disable_r4();
    do_reset();
    wr(8'h00);
    go(0, 1); go(1, 1); go(1, 0);
    check("R4 no inc", c_inc, 0);
    check("R4 no dec", c_dec, 0);
  endtask

  task automatic t_filter_r5();
    do_reset();
    wr(8'h0B);
    @(negedge clk); ph90 = 1;
    repeat (3) @(negedge clk); ph90 = 0;
    repeat (16) @(negedge clk);
    check("R5 short inc", c_inc, 0);
    check("R5 short dec", c_dec, 0);
    @(negedge clk); ph90 = 1;
    repeat (4) @(negedge clk); ph90 = 0;
    repeat (16) @(negedge clk);
    check("R5 long inc", c_inc, 1);
    check("R5 long dec", c_dec, 1);
  endtask

  task automatic t_latency_r6();
    do_reset();
    wr(8'h08);
    @(negedge clk); ph90 = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); check("R6 len0 early", inc, 0);
    @(negedge clk); check("R6 len0 strobe", inc, 1);
    @(negedge clk); check("R6 len0 single", inc, 0);
    go(0, 0);
    wr(8'h0A);
    @(negedge clk); ph90 = 1;
    repeat (5) @(posedge clk);
    @(negedge clk); check("R6 len2 early", inc, 0);
    @(negedge clk); check("R6 len2 strobe", inc, 1);
    repeat (16) @(negedge clk);
  endtask

  task automatic t_illegal_r7();
    do_reset();
    wr(8'h09);
    go(1, 1);
    check("R7 no inc", c_inc, 0);
    check("R7 no dec", c_dec, 0);
    check("R7 err set", err, 1);
    go(1, 0);
    check("R7 err sticky", err, 1);
    check("R7 legal after", c_inc, 1);
  endtask

  task automatic t_index_r8();
    do_reset();
    wr(8'h38);
    @(negedge clk); idx = 1;
    repeat (16) @(negedge clk);
    check("R8 wrong state", c_idx, 0);
    go(0, 1);
    check("R8 match", c_idx, 1);
    go(0, 0);
    @(negedge clk); idx = 0;
    repeat (16) @(negedge clk);
    wr(8'h28);
    @(negedge clk); idx = 1;
    repeat (4) @(negedge clk);
    go(0, 1);
    check("R8 disabled", c_idx, 1);
  endtask

  task automatic t_both_r9();
    do_reset();
    wr(8'h08);
    for (int k = 0; k < 4; k++) begin
      go(0, 1); go(1, 1); go(0, 1); go(0, 0);
    end
    check("R9 inc", c_inc, 8);
    check("R9 dec", c_dec, 8);
  endtask

  initial begin
    fork
      begin
        t_reset_r1();
        t_reg_r2();
        t_fwd_rev_r3();
        t_disable_r4();
        t_filter_r5();
        t_latency_r6();
        t_illegal_r7();
        t_index_r8();
        t_both_r9();
      end
      begin
        repeat (100000) @(posedge clk);
        check("watchdog", 1, 0);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule